// File: doc/BRIEF.md
# Multi-Zone External Bus Controller

This block turns single-word requests from an on-chip processor into timed cycles on an external memory bus. An internal address is matched against three windows. The small window starting at 0x004000 maps to chip select bit 0. The two 1M-word windows at 0x100000 and 0x200000 map to chip select bits 1 and 2. The two large windows share the same external address range, 0x00000 to 0xFFFFF, and only the chip select tells them apart. Every other address is unmapped, including the reserved gaps between the windows, and no bus cycle is run for it.

Each mapped cycle runs three phases: a setup (lead) phase, a strobe (active) phase and a hold (trail) phase. The cycle count of each phase is set per zone. The strobe phase can be stretched by the external ready input. One global enable gates every zone at once, and one clock-enable input freezes all sequencing. An outside master can take the bus through a hold request and hold acknowledge pair. The block hands the bus over only between cycles, and it releases its pins while the bus is handed over.

Top module: `ext_bus_ctrl`

## Requirements
- R1: Addresses 0x004000 to 0x004FFF select the small zone. Only `xcs_n[0]` goes low, and `xa` carries the address minus 0x004000.
- R2: Addresses 0x100000 to 0x1FFFFF drive only `xcs_n[1]` low, and addresses 0x200000 to 0x2FFFFF drive only `xcs_n[2]` low. In both cases `xa` carries the address minus the window base, so both windows use external addresses 0x00000 to 0xFFFFF.
- R3: An accepted request to any other address (reserved or unmapped) drives no chip select and no strobe. `cpu_done` rises in the cycle right after acceptance, with `cpu_rdata` equal to 0.
- R4: While `if_enable` is 0, every request is completed as in R3, and no external cycle starts.
- R5: A mapped cycle holds its chip select low for L+A+T cycles. `cpu_done` is seen L+A+T+1 cycles after the request cycle. L, A and T are the zone's 4-bit fields at bits [4z+3:4z] of `cfg_lead`, `cfg_active` and `cfg_trail`, and a field value of 0 counts as 1.
- R6: When the strobe phase has lasted A cycles, it continues while `xready` is 0. The strobe lasts max(A, W+1) cycles when `xready` is low for the first W strobe cycles.
- R7: `xrd_n` is low only during the strobe phase of a read, and `xwe_n` only during the strobe phase of a write. `xdir` is 1 during reads and 0 during writes. `xd` carries the write data during the strobe phase of a write.
- R8: Read data is sampled from `xd` on the last strobe cycle. It is returned on `cpu_rdata` with a one-cycle `cpu_done` pulse at the end of the hold phase.
- R9: `xhold_ack` rises only from an idle controller. A hold request that arrives during a cycle is granted only after `cpu_done`. While `xhold_ack` is 1, the pins are released, `xd` can be driven from outside, and no request is accepted (`cpu_ready` is 0).
- R10: While `clk_en` is 0, all sequencing is frozen, and each frozen cycle adds one cycle to the access.
- R11: At most one chip select is low at any time. It is low from the first setup cycle through the last hold cycle.
- R12: After reset, all chip selects and strobes are high, `xhold_ack` and `cpu_done` are 0, and `cpu_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Sequencing clock enable |
| if_enable | input | 1 | Global enable for all zones |
| cfg_lead | input | 12 | Setup length per zone, 4 bits each |
| cfg_active | input | 12 | Strobe length per zone, 4 bits each |
| cfg_trail | input | 12 | Hold length per zone, 4 bits each |
| cpu_req | input | 1 | Request, taken when cpu_ready and clk_en are high |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 22 | Internal word address |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Controller idle and able to take a request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid with cpu_done |
| xa | output | 20 | External address (released in hold) |
| xd | inout | 32 | External data |
| xcs_n | output | 3 | Active-low zone chip selects |
| xrd_n | output | 1 | Active-low read strobe |
| xwe_n | output | 1 | Active-low write strobe |
| xdir | output | 1 | Direction, 1 for reads |
| xready | input | 1 | External ready, extends the strobe phase |
| xhold_req | input | 1 | Outside master bus request |
| xhold_ack | output | 1 | Bus granted to the outside master |

## Verification
On every cycle, the assertions check several properties. At most one chip select is active, and a strobe appears only in the strobe phase of the matching direction. The controller waits while ready is low, the grant rises only from idle, and a disabled clock enable freezes the phase. Decoded addresses, the exact phase lengths of each zone, returned read data, the zero-means-one rule, the added cycles from stalls and late ready, and the pin release during a grant show up only as end-to-end results. The bench's directed and random scenarios compare these results against independently computed values.

// File: rtl/ebc_pkg.sv
package ebc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_LEAD   = 3'd1,
    PH_ACTIVE = 3'd2,
    PH_TRAIL  = 3'd3,
    PH_HOLD   = 3'd4
  } phase_t;

  // inclusive lower bound of a zone window (zone index = chip select bit)
  function automatic logic [31:0] zone_lo(input int unsigned z);
    case (z)
      0:       return 32'h0000_4000;
      1:       return 32'h0010_0000;
      default: return 32'h0020_0000;
    endcase
  endfunction

  // exclusive upper bound of a zone window
  function automatic logic [31:0] zone_hi(input int unsigned z);
    case (z)
      0:       return 32'h0000_5000;
      1:       return 32'h0020_0000;
      default: return 32'h0030_0000;
    endcase
  endfunction

  // counter preload: a programmed length of 0 behaves as 1
  function automatic logic [7:0] len_preload(input logic [7:0] n);
    return (n == 8'd0) ? 8'd0 : n - 8'd1;
  endfunction

endpackage

// File: rtl/ebc_decode.sv
module ebc_decode
  import ebc_pkg::*;
#(
  parameter int AW  = 22,
  parameter int XAW = 20,
  parameter int NZ  = 3,
  localparam int ZW = (NZ > 1) ? $clog2(NZ) : 1
) (
  input  logic [AW-1:0]  addr,
  output logic           hit,
  output logic [ZW-1:0]  zone,
  output logic [XAW-1:0] offset
);

  logic [31:0] addr32;
  logic [31:0] diff;

  assign addr32 = 32'(addr);

  always_comb begin
    hit    = 1'b0;
    zone   = '0;
    offset = '0;
    diff   = '0;
    for (int z = 0; z < NZ; z++) begin
      if (addr32 >= zone_lo(z) && addr32 < zone_hi(z)) begin
        hit    = 1'b1;
        zone   = ZW'(z);
        diff   = addr32 - zone_lo(z);
        offset = diff[XAW-1:0];
      end
    end
  end

endmodule

// File: rtl/ebc_phase_seq.sv
module ebc_phase_seq
  import ebc_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en,
  input  logic          start,
  input  logic          hold_req,
  input  logic          xready,
  input  logic [CW-1:0] lead_len,
  input  logic [CW-1:0] act_len,
  input  logic [CW-1:0] trail_len,
  output phase_t        phase,
  output logic          idle_ready,
  output logic          cap_evt,
  output logic          end_evt,
  output logic          hold_ack
);

  logic [CW-1:0] cnt;
  logic          cnt_zero;

  assign cnt_zero   = (cnt == '0);
  assign idle_ready = (phase == PH_IDLE) && !hold_req;
  assign cap_evt    = clk_en && (phase == PH_ACTIVE) && cnt_zero && xready;
  assign end_evt    = clk_en && (phase == PH_TRAIL) && cnt_zero;
  assign hold_ack   = (phase == PH_HOLD);

  function automatic logic [CW-1:0] preload(input logic [CW-1:0] n);
    logic [7:0] p;
    p = len_preload(8'(n));
    return p[CW-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (clk_en) begin
      case (phase)
        PH_IDLE: begin
          if (hold_req) begin
            phase <= PH_HOLD;
          end else if (start) begin
            phase <= PH_LEAD;
            cnt   <= preload(lead_len);
          end
        end
        PH_LEAD: begin
          if (cnt_zero) begin
            phase <= PH_ACTIVE;
            cnt   <= preload(act_len);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_ACTIVE: begin
          if (!cnt_zero) begin
            cnt <= cnt - 1'b1;
          end else if (xready) begin
            phase <= PH_TRAIL;
            cnt   <= preload(trail_len);
          end
        end
        PH_TRAIL: begin
          if (cnt_zero) phase <= PH_IDLE;
          else          cnt   <= cnt - 1'b1;
        end
        PH_HOLD: begin
          if (!hold_req) phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assert_ready_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ACTIVE && cnt_zero && !xready) |=> (phase == PH_ACTIVE));

  assert_lead_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && phase == PH_LEAD && cnt_zero) |=> (phase == PH_ACTIVE));

  assert_grant_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_ack) |-> ($past(phase) == PH_IDLE));

  assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(phase) && $stable(cnt)));

endmodule

// File: rtl/ebc_pin_drive.sv
module ebc_pin_drive
  import ebc_pkg::*;
#(
  parameter int XAW = 20,
  parameter int DW  = 32,
  parameter int NZ  = 3,
  localparam int ZW = (NZ > 1) ? $clog2(NZ) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  phase_t         phase,
  input  logic [ZW-1:0]  zone,
  input  logic           we,
  input  logic [XAW-1:0] offset,
  input  logic [DW-1:0]  wdata,
  output logic [XAW-1:0] xa,
  inout  wire  [DW-1:0]  xd,
  output logic [NZ-1:0]  xcs_n,
  output logic           xrd_n,
  output logic           xwe_n,
  output logic           xdir
);

  logic          busy;
  logic          released;
  logic [NZ-1:0] cs_int;
  logic          rd_int;
  logic          wr_int;
  logic          dir_int;

  assign busy     = (phase == PH_LEAD) || (phase == PH_ACTIVE) || (phase == PH_TRAIL);
  assign released = (phase == PH_HOLD);

  for (genvar z = 0; z < NZ; z++) begin : g_cs
    assign cs_int[z] = !(busy && (zone == ZW'(z)));
  end

  assign rd_int  = !((phase == PH_ACTIVE) && !we);
  assign wr_int  = !((phase == PH_ACTIVE) && we);
  assign dir_int = !(busy && we);

  assign xcs_n = released ? {NZ{1'bz}}  : cs_int;
  assign xrd_n = released ? 1'bz        : rd_int;
  assign xwe_n = released ? 1'bz        : wr_int;
  assign xdir  = released ? 1'bz        : dir_int;
  assign xa    = released ? {XAW{1'bz}} : offset;
  assign xd    = (busy && we) ? wdata : {DW{1'bz}};

  assert_cs_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_int));

  assert_rd_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_int |-> (!we && phase == PH_ACTIVE && cs_int != {NZ{1'b1}}));

  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_int && !wr_int));

  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    released |-> (cs_int == {NZ{1'b1}} && rd_int && wr_int));

endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
  import ebc_pkg::*;
#(
  parameter int AW  = 22,
  parameter int XAW = 20,
  parameter int DW  = 32,
  parameter int NZ  = 3,
  parameter int CW  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             if_enable,
  input  logic [NZ*CW-1:0] cfg_lead,
  input  logic [NZ*CW-1:0] cfg_active,
  input  logic [NZ*CW-1:0] cfg_trail,
  input  logic             cpu_req,
  input  logic             cpu_we,
  input  logic [AW-1:0]    cpu_addr,
  input  logic [DW-1:0]    cpu_wdata,
  output logic             cpu_ready,
  output logic             cpu_done,
  output logic [DW-1:0]    cpu_rdata,
  output logic [XAW-1:0]   xa,
  inout  wire  [DW-1:0]    xd,
  output logic [NZ-1:0]    xcs_n,
  output logic             xrd_n,
  output logic             xwe_n,
  output logic             xdir,
  input  logic             xready,
  input  logic             xhold_req,
  output logic             xhold_ack
);

  localparam int ZW = (NZ > 1) ? $clog2(NZ) : 1;

  logic           dec_hit;
  logic [ZW-1:0]  dec_zone;
  logic [XAW-1:0] dec_off;

  phase_t         phase;
  logic           take, start_evt, miss_evt, cap_evt, end_evt;
  logic [ZW-1:0]  zone_q, sel_zone;
  logic           we_q;
  logic [XAW-1:0] off_q;
  logic [DW-1:0]  wdata_q, rdata_q;
  logic [CW-1:0]  lead_sel, act_sel, trail_sel;

  ebc_decode #(.AW(AW), .XAW(XAW), .NZ(NZ)) u_decode (
    .addr   (cpu_addr),
    .hit    (dec_hit),
    .zone   (dec_zone),
    .offset (dec_off)
  );

  assign take      = cpu_req && cpu_ready && clk_en;
  assign start_evt = take && dec_hit && if_enable;
  assign miss_evt  = take && !(dec_hit && if_enable);

  // timing fields come from the decoded zone at start, from the held zone afterwards
  assign sel_zone  = (phase == PH_IDLE) ? dec_zone : zone_q;
  assign lead_sel  = cfg_lead  [int'(sel_zone)*CW +: CW];
  assign act_sel   = cfg_active[int'(sel_zone)*CW +: CW];
  assign trail_sel = cfg_trail [int'(sel_zone)*CW +: CW];

  ebc_phase_seq #(.CW(CW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en     (clk_en),
    .start      (start_evt),
    .hold_req   (xhold_req),
    .xready     (xready),
    .lead_len   (lead_sel),
    .act_len    (act_sel),
    .trail_len  (trail_sel),
    .phase      (phase),
    .idle_ready (cpu_ready),
    .cap_evt    (cap_evt),
    .end_evt    (end_evt),
    .hold_ack   (xhold_ack)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zone_q    <= '0;
      we_q      <= 1'b0;
      off_q     <= '0;
      wdata_q   <= '0;
      rdata_q   <= '0;
      cpu_done  <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      cpu_done <= end_evt || miss_evt;
      if (start_evt) begin
        zone_q  <= dec_zone;
        we_q    <= cpu_we;
        off_q   <= dec_off;
        wdata_q <= cpu_wdata;
        rdata_q <= '0;
      end
      if (cap_evt && !we_q) rdata_q <= xd;
      if (end_evt)       cpu_rdata <= rdata_q;
      else if (miss_evt) cpu_rdata <= '0;
    end
  end

  ebc_pin_drive #(.XAW(XAW), .DW(DW), .NZ(NZ)) u_pins (
    .clk    (clk),
    .rst_n  (rst_n),
    .phase  (phase),
    .zone   (zone_q),
    .we     (we_q),
    .offset (off_q),
    .wdata  (wdata_q),
    .xa     (xa),
    .xd     (xd),
    .xcs_n  (xcs_n),
    .xrd_n  (xrd_n),
    .xwe_n  (xwe_n),
    .xdir   (xdir)
  );

  assert_disabled_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!if_enable && phase == PH_IDLE) |=> (phase != PH_LEAD));

  assert_miss_no_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt |=> (phase == PH_IDLE && cpu_done));

  assert_done_after_trail_R8: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> (cpu_done && phase != PH_TRAIL));

endmodule

// File: tb/ext_bus_ctrl_test.sv
module ext_bus_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_en = 1'b1;
  logic        if_enable = 1'b1;
  logic [11:0] cfg_lead = '0, cfg_active = '0, cfg_trail = '0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [21:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_ready, cpu_done;
  logic [31:0] cpu_rdata;
  logic [19:0] xa;
  wire  [31:0] xd;
  logic [2:0]  xcs_n;
  logic        xrd_n, xwe_n, xdir;
  logic        xready = 1'b1;
  logic        xhold_req = 1'b0;
  logic        xhold_ack;

  logic        master_on = 1'b0;
  logic [31:0] master_val = 32'h1357_9BDF;
  int          wait_cfg = 0;
  int          act_k = 0;
  int          n_checks = 0, n_fail = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  function automatic logic [31:0] pat(input logic [19:0] a);
    return {a[11:0], a} ^ 32'h5A3C_96E1;
  endfunction

  assign xd = master_on ? master_val : ((xrd_n === 1'b0) ? pat(xa) : 32'hzzzz_zzzz);

  ext_bus_ctrl uut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .if_enable(if_enable),
    .cfg_lead(cfg_lead), .cfg_active(cfg_active), .cfg_trail(cfg_trail),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .xa(xa), .xd(xd), .xcs_n(xcs_n), .xrd_n(xrd_n), .xwe_n(xwe_n), .xdir(xdir),
    .xready(xready), .xhold_req(xhold_req), .xhold_ack(xhold_ack)
  );

  // external device: ready low for the first wait_cfg strobe cycles
  always @(negedge clk) begin
    if (xrd_n === 1'b0 || xwe_n === 1'b0) begin
      act_k  <= act_k + 1;
      xready <= ((act_k + 1) > wait_cfg);
    end else begin
      act_k  <= 0;
      xready <= 1'b1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int eff(input logic [3:0] c);
    return (c == 4'd0) ? 1 : int'(c);
  endfunction

  function automatic void model_decode(input logic [21:0] a, output bit hit,
                                       output int zi, output logic [19:0] off);
    hit = 1'b1; zi = 0; off = '0;
    if (a >= 22'h004000 && a <= 22'h004FFF)      begin zi = 0; off = 20'(a - 22'h004000); end
    else if (a >= 22'h100000 && a <= 22'h1FFFFF) begin zi = 1; off = 20'(a - 22'h100000); end
    else if (a >= 22'h200000 && a <= 22'h2FFFFF) begin zi = 2; off = 20'(a - 22'h200000); end
    else hit = 1'b0;
  endfunction

  task automatic do_access(input logic [21:0] a, input bit we, input logic [31:0] wd,
                           input int w, input int stall, input bit hold_mid);
    bit hit; int zi; logic [19:0] off;
    int ex_len, ex_act, cycles, st_left, strobe_n;
    int cs_n_cnt[3];
    bit dir_bad, xa_bad, wd_bad, hold_bad;
    string rz;
    model_decode(a, hit, zi, off);
    if (!if_enable) hit = 1'b0;
    ex_act = (eff(cfg_active[zi*4 +: 4]) > w + 1) ? eff(cfg_active[zi*4 +: 4]) : w + 1;
    ex_len = eff(cfg_lead[zi*4 +: 4]) + ex_act + eff(cfg_trail[zi*4 +: 4]) + stall;
    rz = (zi == 0) ? "R1" : "R2";
    while (!cpu_ready) @(negedge clk);
    wait_cfg = w;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 1'b0;
    cycles = 1; strobe_n = 0; cs_n_cnt = '{0, 0, 0};
    dir_bad = 0; xa_bad = 0; wd_bad = 0; hold_bad = 0;
    st_left = stall;
    if (stall > 0) clk_en = 1'b0;
    if (hold_mid) xhold_req = 1'b1;
    while (!cpu_done && cycles < 300) begin
      for (int z = 0; z < 3; z++) if (xcs_n[z] === 1'b0) cs_n_cnt[z]++;
      if (xhold_ack) hold_bad = 1;
      if (xcs_n !== 3'b111 && xa !== off) xa_bad = 1;
      if (xrd_n === 1'b0) begin strobe_n++; if (xdir !== 1'b1 || we) dir_bad = 1; end
      if (xwe_n === 1'b0) begin
        strobe_n++;
        if (xdir !== 1'b0 || !we) dir_bad = 1;
        if (xd !== wd) wd_bad = 1;
      end
      @(negedge clk);
      cycles++;
      if (st_left > 0) begin st_left--; if (st_left == 0) clk_en = 1'b1; end
    end
    clk_en = 1'b1;
    if (hit) begin
      check(cycles == ex_len + 1, "R5", "request-to-done cycles", cycles, ex_len + 1);
      check(cs_n_cnt[zi] == ex_len, "R11", "chip select low cycles", cs_n_cnt[zi], ex_len);
      check(cs_n_cnt[0] + cs_n_cnt[1] + cs_n_cnt[2] == ex_len, rz, "other chip selects",
            cs_n_cnt[0] + cs_n_cnt[1] + cs_n_cnt[2], ex_len);
      check(strobe_n == ex_act - stall * 0, "R6", "strobe cycles", strobe_n, ex_act);
      check(!xa_bad, rz, "external address", xa_bad, 0);
      check(!dir_bad, "R7", "strobe/direction", dir_bad, 0);
      if (we) check(!wd_bad, "R7", "write data on bus", wd_bad, 0);
      else    check(cpu_rdata == pat(off), "R8", "read data", cpu_rdata, pat(off));
      if (stall > 0) check(cycles == ex_len + 1, "R10", "stalled length", cycles, ex_len + 1);
    end else begin
      check(cycles == 1, if_enable ? "R3" : "R4", "miss done latency", cycles, 1);
      check(cs_n_cnt[0] + cs_n_cnt[1] + cs_n_cnt[2] == 0 && strobe_n == 0,
            if_enable ? "R3" : "R4", "no external cycle", strobe_n, 0);
      check(cpu_rdata == 32'h0, "R3", "miss read data", cpu_rdata, 0);
    end
    if (hold_mid) begin
      check(!hold_bad, "R9", "grant during cycle", hold_bad, 0);
      @(negedge clk);
      check(xhold_ack == 1'b1 && cpu_ready == 1'b0, "R9", "grant after done", xhold_ack, 1);
      xhold_req = 1'b0;
      @(negedge clk);
      check(xhold_ack == 1'b0, "R9", "grant released", xhold_ack, 0);
    end
    @(negedge clk);
    check(cpu_done == 1'b0, "R8", "done is one cycle", cpu_done, 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [21:0] addrs[13];
    void'($urandom(32'd777));
    addrs = '{22'h004000, 22'h004FFF, 22'h005000, 22'h003FFF, 22'h100000, 22'h1FFFFF,
              22'h200000, 22'h2FFFFF, 22'h300000, 22'h010000, 22'h0FFFFF, 22'h1234AB, 22'h27ABCD};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(xcs_n === 3'b111 && xrd_n === 1'b1 && xwe_n === 1'b1, "R12", "pins after reset",
          {xcs_n, xrd_n, xwe_n}, 5'h1F);
    check(cpu_done == 0 && xhold_ack == 0 && cpu_ready == 1, "R12", "status after reset",
          {cpu_done, xhold_ack, cpu_ready}, 3'b001);

    // directed: zero lengths count as one, boundaries of every window
    cfg_lead = 12'h000; cfg_active = 12'h000; cfg_trail = 12'h000;
    foreach (addrs[i]) do_access(addrs[i], 1'b0, 32'h0, 0, 0, 1'b0);
    cfg_lead = 12'h321; cfg_active = 12'h254; cfg_trail = 12'h132;
    foreach (addrs[i]) do_access(addrs[i], 1'b1, 32'hC0DE_0000 | i, 0, 0, 1'b0);

    // late ready, stalls, hold during a cycle
    do_access(22'h004123, 1'b0, 32'h0, 6, 0, 1'b0);
    do_access(22'h1ABCDE, 1'b1, 32'hFACE_B00C, 3, 2, 1'b0);
    do_access(22'h2000FF, 1'b0, 32'h0, 0, 3, 1'b1);

    // global enable off
    if_enable = 1'b0;
    do_access(22'h004010, 1'b0, 32'h0, 0, 0, 1'b0);
    do_access(22'h200010, 1'b1, 32'h1, 0, 0, 1'b0);
    if_enable = 1'b1;

    // grant while idle: pins released, request refused, hold wins over request
    xhold_req = 1'b1; cpu_req = 1'b1; cpu_addr = 22'h004000; cpu_we = 1'b0;
    @(negedge clk);
    cpu_req = 1'b0;
    check(xhold_ack == 1'b1 && cpu_ready == 1'b0, "R9", "grant from idle", xhold_ack, 1);
    master_on = 1'b1;
    repeat (2) @(negedge clk);
    check(xd === master_val, "R9", "bus released to master", xd, master_val);
    check(cpu_done == 1'b0, "R9", "request ignored in hold", cpu_done, 0);
    master_on = 1'b0; xhold_req = 1'b0;
    @(negedge clk);
    check(xhold_ack == 1'b0 && cpu_done == 1'b0, "R9", "grant dropped", xhold_ack, 0);

    // constrained random
    for (int it = 0; it < 80; it++) begin
      logic [21:0] a;
      int sel;
      sel = $urandom_range(0, 4);
      case (sel)
        0: a = 22'h004000 + 22'($urandom_range(0, 22'hFFF));
        1: a = 22'h100000 + 22'($urandom_range(0, 22'hFFFFF));
        2: a = 22'h200000 + 22'($urandom_range(0, 22'hFFFFF));
        3: a = 22'h300000 + 22'($urandom_range(0, 22'hFFFFF));
        default: a = 22'($urandom_range(0, 22'h0FFFFF));
      endcase
      cfg_lead   = 12'($urandom); cfg_active = 12'($urandom); cfg_trail = 12'($urandom);
      cfg_lead   &= 12'h777; cfg_active &= 12'h777; cfg_trail &= 12'h777;
      do_access(a, 1'($urandom), $urandom, $urandom_range(0, 4),
                ($urandom_range(0, 3) == 0) ? $urandom_range(1, 3) : 0,
                ($urandom_range(0, 7) == 0));
    end
    summary();
  end

endmodule